// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block turns the match settings of a bank of memory protection entries into explicit inclusive byte ranges. Each entry has a two-bit match mode and an address register holding a byte address divided by four. When the control register file changes an entry, it pulses an update strobe together with the entry index. One clock later the block has stored a start and an end byte address for that entry, each two bits wider than the address register, so that an access checker can compare an address against plain bounds instead of decoding modes on every access.

Four match modes are supported: off; top-of-range, where the region runs from the previous entry's address up to this entry's address; a naturally aligned four-byte word; and a naturally aligned power-of-two region whose size comes from the number of trailing ones in the address register. An address register that is all ones in power-of-two mode covers the whole address space. On every strobe the block also refreshes a count of how many entries have a match mode other than off.

Top module: `region_bound_decoder`

## Requirements
- R1: Mode code 0 (off) stores start 0 and end all-ones (full bound width) for the strobed entry.
- R2: Mode code 1 (top-of-range) stores start = previous entry's address register times 4 and end = this register times 4 minus 1, wrapping modulo the bound width; entry 0 uses 0 as its previous address.
- R3: Mode code 2 (four-byte word) stores start = address register times 4 and end = start + 3.
- R4: Mode code 3 (power-of-two), with t trailing ones in a register that is not all ones, stores start = (register with its low t bits cleared) times 4 and end = start + 2^(t+3) - 1.
- R5: Mode code 3 with an all-ones address register stores start 0 and end all-ones.
- R6: On each strobe the active count becomes the number of entries, over the whole bank, whose mode code is not 0.
- R7: Results appear on the outputs one clock after the strobe; only the strobed entry's bounds change, and without a strobe no output changes whatever the mode and address inputs do.
- R8: After reset every entry reads start 0 and end all-ones, and the active count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid_i | input | 1 | Update strobe for one entry |
| upd_idx_i | input | IW = clog2(NUM_ENTRIES) | Index of the entry to update |
| mode_flat_i | input | 2*NUM_ENTRIES | Match mode of every entry, entry i at bits [2i+1:2i] |
| addr_flat_i | input | ADDR_W*NUM_ENTRIES | Address register of every entry, entry i at [i*ADDR_W +: ADDR_W] |
| lo_flat_o | output | BW*NUM_ENTRIES | Inclusive start byte address per entry, BW = ADDR_W+2 |
| hi_flat_o | output | BW*NUM_ENTRIES | Inclusive end byte address per entry |
| active_cnt_o | output | clog2(NUM_ENTRIES+1) | Number of entries whose mode is not off |

## Verification
The assertions assume that the strobe index names an existing entry and that the mode and address inputs carry known values in the cycle the strobe is high; they say nothing about those inputs in other cycles. The stimulus only uses indices below the entry count and changes the mode and address inputs only on the falling edge, so the values sampled with a strobe are settled. Between strobes the bench deliberately alters other entries' addresses and modes to exercise the hold behaviour without breaking those assumptions.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    typedef enum logic [1:0] {
        MM_OFF   = 2'd0,
        MM_TOR   = 2'd1,
        MM_WORD  = 2'd2,
        MM_POW2  = 2'd3
    } match_mode_e;
endpackage

// File: rtl/rbd_ones_run.sv
module rbd_ones_run #(
    parameter int W  = 16,
    localparam int TW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val_i,
    output logic [TW-1:0] run_o,
    output logic          all_ones_o
);
    // Lowest zero bit position equals the number of trailing ones.
    always_comb begin
        run_o      = TW'(W);
        all_ones_o = &val_i;
        for (int b = W - 1; b >= 0; b--) begin
            if (!val_i[b]) begin
                run_o = TW'(b);
            end
        end
    end
endmodule

// File: rtl/rbd_span_calc.sv
module rbd_span_calc #(
    parameter int AW = 16,
    localparam int BW = AW + 2,
    localparam int TW = $clog2(AW + 1)
) (
    input  rbd_pkg::match_mode_e mode_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [AW-1:0]        prev_i,
    output logic [BW-1:0]        lo_o,
    output logic [BW-1:0]        hi_o
);
    logic [TW-1:0] run;
    logic          full;
    logic [AW:0]   clr_mask;
    logic [BW:0]   span_mask;
    logic [TW+1:0] span_sh;
    logic [AW-1:0] pow2_base;

    rbd_ones_run #(.W(AW)) u_run (
        .val_i      (addr_i),
        .run_o      (run),
        .all_ones_o (full)
    );

    always_comb begin
        span_sh   = {2'b00, run} + (TW+2)'(3);
        clr_mask  = ((AW+1)'(1) << run) - (AW+1)'(1);
        span_mask = ((BW+1)'(1) << span_sh) - (BW+1)'(1);
        pow2_base = addr_i & ~clr_mask[AW-1:0];
    end

    always_comb begin
        lo_o = '0;
        hi_o = '1;
        unique case (mode_i)
            rbd_pkg::MM_OFF: begin
                lo_o = '0;
                hi_o = '1;
            end
            rbd_pkg::MM_TOR: begin
                lo_o = {prev_i, 2'b00};
                hi_o = {addr_i, 2'b00} - BW'(1);
            end
            rbd_pkg::MM_WORD: begin
                lo_o = {addr_i, 2'b00};
                hi_o = {addr_i, 2'b11};
            end
            rbd_pkg::MM_POW2: begin
                if (full) begin
                    lo_o = '0;
                    hi_o = '1;
                end else begin
                    lo_o = {pow2_base, 2'b00};
                    hi_o = {pow2_base, 2'b00} | span_mask[BW-1:0];
                end
            end
            default: begin
                lo_o = '0;
                hi_o = '1;
            end
        endcase
    end
endmodule

// File: rtl/rbd_rule_tally.sv
module rbd_rule_tally #(
    parameter int N  = 8,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [2*N-1:0] mode_flat_i,
    output logic [CW-1:0]  count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            if (mode_flat_i[2*i +: 2] != 2'b00) begin
                count_o = count_o + CW'(1);
            end
        end
    end
endmodule

// File: rtl/region_bound_decoder.sv
module region_bound_decoder #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 16,
    localparam int BW = ADDR_W + 2,
    localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CW = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_valid_i,
    input  logic [IW-1:0]                 upd_idx_i,
    input  logic [2*NUM_ENTRIES-1:0]      mode_flat_i,
    input  logic [ADDR_W*NUM_ENTRIES-1:0] addr_flat_i,
    output logic [BW*NUM_ENTRIES-1:0]     lo_flat_o,
    output logic [BW*NUM_ENTRIES-1:0]     hi_flat_o,
    output logic [CW-1:0]                 active_cnt_o
);
    typedef struct packed {
        logic [NUM_ENTRIES-1:0][BW-1:0] lo;
        logic [NUM_ENTRIES-1:0][BW-1:0] hi;
        logic [CW-1:0]                  cnt;
    } bounds_t;

    bounds_t st_d, st_q;

    rbd_pkg::match_mode_e sel_mode;
    logic [ADDR_W-1:0]    sel_addr;
    logic [ADDR_W-1:0]    sel_prev;
    logic [BW-1:0]        calc_lo;
    logic [BW-1:0]        calc_hi;
    logic [CW-1:0]        tally;

    // Select the strobed entry and its lower neighbour.
    always_comb begin
        sel_mode = rbd_pkg::MM_OFF;
        sel_addr = '0;
        sel_prev = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (IW'(i) == upd_idx_i) begin
                sel_mode = rbd_pkg::match_mode_e'(mode_flat_i[2*i +: 2]);
                sel_addr = addr_flat_i[i*ADDR_W +: ADDR_W];
                if (i > 0) begin
                    sel_prev = addr_flat_i[((i > 0) ? i - 1 : 0)*ADDR_W +: ADDR_W];
                end
            end
        end
    end

    rbd_span_calc #(.AW(ADDR_W)) u_span (
        .mode_i (sel_mode),
        .addr_i (sel_addr),
        .prev_i (sel_prev),
        .lo_o   (calc_lo),
        .hi_o   (calc_hi)
    );

    rbd_rule_tally #(.N(NUM_ENTRIES)) u_tally (
        .mode_flat_i (mode_flat_i),
        .count_o     (tally)
    );

    always_comb begin
        st_d = st_q;
        if (upd_valid_i) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (IW'(i) == upd_idx_i) begin
                    st_d.lo[i] = calc_lo;
                    st_d.hi[i] = calc_hi;
                end
            end
            st_d.cnt = tally;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                st_q.lo[i] <= '0;
                st_q.hi[i] <= '1;
            end
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            lo_flat_o[i*BW +: BW] = st_q.lo[i];
            hi_flat_o[i*BW +: BW] = st_q.hi[i];
        end
    end
    assign active_cnt_o = st_q.cnt;

    // R7: nothing moves without a strobe.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> ($stable(lo_flat_o) && $stable(hi_flat_o) && $stable(active_cnt_o)));

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
        logic [BW:0] span_len;
        assign span_len = {1'b0, hi_flat_o[g*BW +: BW]} - {1'b0, lo_flat_o[g*BW +: BW]} + (BW+1)'(1);

        // R1: off entries span everything.
        a_r1_off_full: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid_i && upd_idx_i == IW'(g) && mode_flat_i[2*g +: 2] == 2'd0)
            |=> (lo_flat_o[g*BW +: BW] == '0 && hi_flat_o[g*BW +: BW] == '1));

        // R3: four-byte words span exactly four bytes.
        a_r3_word_span: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid_i && upd_idx_i == IW'(g) && mode_flat_i[2*g +: 2] == 2'd2)
            |=> (span_len == (BW+1)'(4)));

        // R4, R5: power-of-two regions have a power-of-two length.
        a_r4_pow2_len: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid_i && upd_idx_i == IW'(g) && mode_flat_i[2*g +: 2] == 2'd3)
            |=> ($countones(span_len) == 1));

        // R7: other entries keep their bounds across a strobe.
        a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid_i && upd_idx_i != IW'(g))
            |=> ($stable(lo_flat_o[g*BW +: BW]) && $stable(hi_flat_o[g*BW +: BW])));
    end
endmodule

// File: tb/tb_region_bound_decoder.sv
`timescale 1ns/1ps
module tb_region_bound_decoder;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int BW = AW + 2;
    localparam int IW = 2;
    localparam int CW = 3;
    localparam int FULL = (1 << BW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_valid_i = 1'b0;
    logic [IW-1:0]     upd_idx_i = '0;
    logic [2*N-1:0]    mode_flat_i = '0;
    logic [AW*N-1:0]   addr_flat_i = '0;
    logic [BW*N-1:0]   lo_flat_o;
    logic [BW*N-1:0]   hi_flat_o;
    logic [CW-1:0]     active_cnt_o;

    int total = 0;
    int bad = 0;
    int mode_v [N];
    int addr_v [N];
    int exp_lo [N];
    int exp_hi [N];
    int exp_cnt = 0;

    always #10 clk = ~clk;

    region_bound_decoder #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut (
        .clk, .rst_n, .upd_valid_i, .upd_idx_i, .mode_flat_i, .addr_flat_i,
        .lo_flat_o, .hi_flat_o, .active_cnt_o
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int m, input int a);
        if (m == 0) return "R1 off";
        if (m == 1) return "R2 top-of-range";
        if (m == 2) return "R3 word";
        if (a == (1 << AW) - 1) return "R5 full pow2";
        return "R4 pow2";
    endfunction

    task automatic model(input int m, input int a, input int p, output int lo, output int hi);
        int t;
        lo = 0;
        hi = FULL;
        if (m == 1) begin
            lo = p * 4;
            hi = (a * 4 - 1) & FULL;
        end else if (m == 2) begin
            lo = a * 4;
            hi = lo + 3;
        end else if (m == 3 && a != (1 << AW) - 1) begin
            t = 0;
            while (((a >> t) & 1) == 1) t++;
            lo = ((a >> t) << t) * 4;
            hi = lo + (1 << (t + 3)) - 1;
        end
    endtask

    task automatic drive_inputs();
        for (int j = 0; j < N; j++) begin
            mode_flat_i[2*j +: 2] = 2'(mode_v[j]);
            addr_flat_i[j*AW +: AW] = AW'(addr_v[j]);
        end
    endtask

    task automatic check_all(input string req);
        for (int j = 0; j < N; j++) begin
            chk(int'(lo_flat_o[j*BW +: BW]) == exp_lo[j], req,
                int'(lo_flat_o[j*BW +: BW]), exp_lo[j]);
            chk(int'(hi_flat_o[j*BW +: BW]) == exp_hi[j], req,
                int'(hi_flat_o[j*BW +: BW]), exp_hi[j]);
        end
        chk(int'(active_cnt_o) == exp_cnt, "R6 count", int'(active_cnt_o), exp_cnt);
    endtask

    task automatic strobe(input int idx);
        int p;
        drive_inputs();
        upd_idx_i   = IW'(idx);
        upd_valid_i = 1'b1;
        p = (idx == 0) ? 0 : addr_v[idx - 1];
        model(mode_v[idx], addr_v[idx], p, exp_lo[idx], exp_hi[idx]);
        exp_cnt = 0;
        for (int j = 0; j < N; j++) if (mode_v[j] != 0) exp_cnt++;
        @(negedge clk);
        upd_valid_i = 1'b0;
        // R7: one register stage, results visible at this falling edge
        check_all({tag_of(mode_v[idx], addr_v[idx]), " / R7"});
    endtask

    initial begin : watchdog
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int j = 0; j < N; j++) begin
            mode_v[j] = 0;
            addr_v[j] = 0;
            exp_lo[j] = 0;
            exp_hi[j] = FULL;
        end
        repeat (2) @(negedge clk);
        // R8: reset state
        check_all("R8 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R8 after release");

        // Exhaustive sweep over entry, mode and address.
        for (int idx = 0; idx < N; idx++) begin
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < (1 << AW); a++) begin
                    for (int j = 0; j < N; j++) begin
                        if (j != idx) begin
                            addr_v[j] = (a * 7 + idx * 13 + j * 5) & ((1 << AW) - 1);
                            mode_v[j] = (a + j) % 4;
                        end
                    end
                    addr_v[idx] = a;
                    mode_v[idx] = m;
                    strobe(idx);
                end
            end
        end

        // R2: entry 0 top-of-range ignores any neighbour, uses 0
        addr_v[N-1] = 63;
        addr_v[0] = 9;
        mode_v[0] = 1;
        strobe(0);
        chk(int'(lo_flat_o[0 +: BW]) == 0, "R2 entry0 start", int'(lo_flat_o[0 +: BW]), 0);

        // R6: all off, then all on
        for (int j = 0; j < N; j++) mode_v[j] = 0;
        strobe(1);
        for (int j = 0; j < N; j++) mode_v[j] = 3;
        strobe(2);

        // R7: no strobe, inputs change, outputs hold
        for (int k = 0; k < 5; k++) begin
            mode_flat_i = 8'(k * 37 + 11);
            addr_flat_i = 24'(k * 123457 + 999);
            @(negedge clk);
            check_all("R7 hold without strobe");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule